// File: doc/BRIEF.md
# Synchronous Queue Buffer with Offset Peek

This block is a single-clock first-in, first-out buffer whose word width and number of entries are set at build time. A producer appends words at the tail through the push port. A consumer takes words from the head through the pop port. Pop data is registered, so it appears one cycle after the request, together with a valid strobe.

The block also exposes its fill state. It drives empty, full and half-full outputs, the current word count, and a level flag that compares the count against a value supplied on an input. A second read path, the peek port, returns the word at a chosen distance from the head. This lets a consumer look ahead into the queue without removing anything.

A push and a pop may arrive in the same cycle. When the queue holds at least one word, both are taken and the count stays the same. When the queue is empty, only the push is taken. A push into a full queue with no pop, and a pop from an empty queue, are dropped and reported with a one-cycle pulse.

Top module: `peek_fifo`

## Requirements
- R1: After a synchronous active-high reset the count is 0, empty is 1, full, half_full, pop_valid, overflow and underflow are 0, and the queue holds no words.
- R2: Words leave in the order they were pushed; pop_data carries the head word and pop_valid is 1 in the cycle after an accepted pop, and pop_valid is 0 after any cycle with no accepted pop.
- R3: count equals the number of stored words and can reach DEPTH, since it is one bit wider than the address.
- R4: empty is 1 exactly when count is 0; full is 1 exactly when count equals DEPTH.
- R5: half_full is 1 exactly when count is greater than or equal to DEPTH/2 (rounded down).
- R6: at_level is 1 exactly when count is greater than or equal to the level input; level 0 keeps it at 1.
- R7: A push and a pop in the same cycle on a non-empty queue, including a full one, are both accepted and leave count unchanged.
- R8: A push and a pop in the same cycle on an empty queue store the pushed word, ignore the pop (pop_valid stays 0), give count 1 and pulse underflow for one cycle.
- R9: A push to a full queue without a pop is dropped: count and stored words stay unchanged and overflow is 1 for exactly the following cycle.
- R10: A pop from an empty queue without a push is dropped: count stays 0, pop_valid stays 0 and underflow is 1 for exactly the following cycle.
- R11: peek_data combinationally returns the word at offset peek_off from the head, where offset 0 is the oldest word, across the storage wrap point, and peeking never changes count or order.
- R12: A peek_off greater than or equal to count gives peek_data 0 and peek_bad 1; otherwise peek_bad is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| push_en | input | 1 | Append push_data at the tail |
| push_data | input | WIDTH | Word to append |
| pop_en | input | 1 | Remove the head word |
| pop_data | output | WIDTH | Registered head word from the last accepted pop |
| pop_valid | output | 1 | pop_data was updated by the previous cycle's pop |
| peek_off | input | AW | Offset from the head to look at |
| peek_data | output | WIDTH | Word at peek_off, or 0 when out of range |
| peek_bad | output | 1 | peek_off is not below count |
| level | input | AW+1 | Fill level the count is compared against |
| count | output | AW+1 | Number of stored words |
| empty | output | 1 | No words stored |
| half_full | output | 1 | count >= DEPTH/2 |
| full | output | 1 | count equals DEPTH |
| at_level | output | 1 | count >= level |
| overflow | output | 1 | One-cycle pulse after a dropped push |
| underflow | output | 1 | One-cycle pulse after a dropped pop |

## Verification
The properties assume that push_en, pop_en, peek_off and level are known, non-X values at every rising edge outside reset, and they make no claim about pop_data while pop_valid is 0. The bench changes all inputs only on the falling edge and keeps them at 0 or valid values throughout. It drives level and peek_off inside their declared widths, so the comparisons used by the assertions always see defined operands. The full-with-pop and empty-with-push cases are reached deliberately, so that the conditional properties for those cases are exercised and not only left vacuous.

// File: rtl/pkf_pkg.sv
package pkf_pkg;

    // Accepted-operation summary for one cycle
    typedef struct packed {
        logic push_ok;
        logic pop_ok;
        logic ovf;
        logic unf;
    } pkf_ops_t;

    // Net effect of the accepted operations on the fill count
    typedef enum logic [1:0] {
        PKF_IDLE = 2'd0,
        PKF_GROW = 2'd1,
        PKF_SHRINK = 2'd2,
        PKF_SWAP = 2'd3
    } pkf_move_e;

    function automatic pkf_ops_t pkf_decide(
        input logic push_req,
        input logic pop_req,
        input logic is_full,
        input logic is_empty
    );
        pkf_ops_t r;
        r.pop_ok  = pop_req && !is_empty;
        r.push_ok = push_req && (!is_full || r.pop_ok);
        r.ovf     = push_req && is_full && !pop_req;
        r.unf     = pop_req && is_empty;
        return r;
    endfunction

    function automatic pkf_move_e pkf_move(input pkf_ops_t o);
        pkf_move_e m;
        unique case ({o.push_ok, o.pop_ok})
            2'b10:   m = PKF_GROW;
            2'b01:   m = PKF_SHRINK;
            2'b11:   m = PKF_SWAP;
            default: m = PKF_IDLE;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/pkf_ctrl.sv
module pkf_ctrl
    import pkf_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int AW    = 3,
    parameter int CW    = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push_en,
    input  logic          pop_en,
    output logic [AW-1:0] head,
    output logic [AW-1:0] tail,
    output logic [CW-1:0] count,
    output logic          push_ok,
    output logic          pop_ok,
    output logic          overflow,
    output logic          underflow
);

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] CAP  = CW'(DEPTH);

    pkf_ops_t  ops;
    pkf_move_e move;
    logic      cnt_full;
    logic      cnt_empty;

    function automatic logic [AW-1:0] advance(input logic [AW-1:0] p);
        return (p == LAST) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        cnt_full  = (count == CAP);
        cnt_empty = (count == '0);
        ops       = pkf_decide(push_en, pop_en, cnt_full, cnt_empty);
        move      = pkf_move(ops);
        push_ok   = ops.push_ok;
        pop_ok    = ops.pop_ok;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head      <= '0;
            tail      <= '0;
            count     <= '0;
            overflow  <= 1'b0;
            underflow <= 1'b0;
        end else begin
            overflow  <= ops.ovf;
            underflow <= ops.unf;
            if (ops.push_ok) tail <= advance(tail);
            if (ops.pop_ok)  head <= advance(head);
            unique case (move)
                PKF_GROW:   count <= count + CW'(1);
                PKF_SHRINK: count <= count - CW'(1);
                default:    count <= count;
            endcase
        end
    end

endmodule

// File: rtl/pkf_store.sv
module pkf_store #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 8,
    parameter int AW    = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    input  logic [AW-1:0]    rd_addr,
    input  logic [AW-1:0]    pk_addr,
    input  logic             pk_kill,
    output logic [WIDTH-1:0] pop_data,
    output logic             pop_valid,
    output logic [WIDTH-1:0] peek_data
);

    logic [WIDTH-1:0] mem [DEPTH];

    // One write-enabled register per entry
    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        always_ff @(posedge clk) begin
            if (wr_en && (wr_addr == AW'(i))) mem[i] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pop_data  <= '0;
            pop_valid <= 1'b0;
        end else begin
            pop_valid <= rd_en;
            if (rd_en) pop_data <= mem[rd_addr];
        end
    end

    always_comb begin
        peek_data = pk_kill ? '0 : mem[pk_addr];
    end

endmodule

// File: rtl/pkf_status.sv
module pkf_status #(
    parameter int DEPTH = 8,
    parameter int CW    = 4
) (
    input  logic [CW-1:0] count,
    input  logic [CW-1:0] level,
    output logic          empty,
    output logic          half_full,
    output logic          full,
    output logic          at_level
);

    localparam logic [CW-1:0] CAP  = CW'(DEPTH);
    localparam logic [CW-1:0] HALF = CW'(DEPTH / 2);

    always_comb begin
        empty     = (count == '0);
        full      = (count == CAP);
        half_full = (count >= HALF);
        at_level  = (count >= level);
    end

endmodule

// File: rtl/pkf_peek_map.sv
module pkf_peek_map #(
    parameter int DEPTH = 8,
    parameter int AW    = 3,
    parameter int CW    = 4
) (
    input  logic [AW-1:0] head,
    input  logic [AW-1:0] offset,
    input  logic [CW-1:0] count,
    output logic [AW-1:0] addr,
    output logic          bad
);

    localparam logic [AW:0] SPAN = (AW + 1)'(DEPTH);

    logic [AW:0] sum;
    logic [AW:0] wrapped;

    always_comb begin
        sum     = {1'b0, head} + {1'b0, offset};
        wrapped = (sum >= SPAN) ? (sum - SPAN) : sum;
        addr    = wrapped[AW-1:0];
        bad     = (CW'(offset) >= count);
    end

endmodule

// File: rtl/peek_fifo.sv
module peek_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_en,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop_en,
    output logic [WIDTH-1:0] pop_data,
    output logic             pop_valid,
    input  logic [AW-1:0]    peek_off,
    output logic [WIDTH-1:0] peek_data,
    output logic             peek_bad,
    input  logic [CW-1:0]    level,
    output logic [CW-1:0]    count,
    output logic             empty,
    output logic             half_full,
    output logic             full,
    output logic             at_level,
    output logic             overflow,
    output logic             underflow
);

    logic [AW-1:0] head;
    logic [AW-1:0] tail;
    logic          push_ok;
    logic          pop_ok;
    logic [AW-1:0] pk_addr;

    pkf_ctrl #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) ctrl_i (
        .clk       (clk),
        .rst       (rst),
        .push_en   (push_en),
        .pop_en    (pop_en),
        .head      (head),
        .tail      (tail),
        .count     (count),
        .push_ok   (push_ok),
        .pop_ok    (pop_ok),
        .overflow  (overflow),
        .underflow (underflow)
    );

    pkf_peek_map #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) map_i (
        .head   (head),
        .offset (peek_off),
        .count  (count),
        .addr   (pk_addr),
        .bad    (peek_bad)
    );

    pkf_store #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW)) store_i (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (push_ok),
        .wr_addr   (tail),
        .wr_data   (push_data),
        .rd_en     (pop_ok),
        .rd_addr   (head),
        .pk_addr   (pk_addr),
        .pk_kill   (peek_bad),
        .pop_data  (pop_data),
        .pop_valid (pop_valid),
        .peek_data (peek_data)
    );

    pkf_status #(.DEPTH(DEPTH), .CW(CW)) status_i (
        .count     (count),
        .level     (level),
        .empty     (empty),
        .half_full (half_full),
        .full      (full),
        .at_level  (at_level)
    );

endmodule

// File: rtl/peek_fifo_chk.sv
module peek_fifo_chk #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 8,
    parameter int AW    = 3,
    parameter int CW    = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             push_en,
    input logic             pop_en,
    input logic             pop_valid,
    input logic [AW-1:0]    peek_off,
    input logic [WIDTH-1:0] peek_data,
    input logic             peek_bad,
    input logic [CW-1:0]    count,
    input logic             empty,
    input logic             full,
    input logic             overflow,
    input logic             underflow
);

    // R4
    flags_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(full && empty));

    // R3
    count_range_chk: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (push_en && full && !pop_en) |=> (overflow && $stable(count)));

    // R10
    no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        (pop_en && !push_en && empty) |=> (underflow && !pop_valid && count == '0));

    // R7
    swap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (push_en && pop_en && !empty) |=> ($stable(count) && pop_valid));

    // R8
    empty_swap_chk: assert property (@(posedge clk) disable iff (rst)
        (push_en && pop_en && empty) |=> (count == CW'(1) && underflow && !pop_valid));

    // R2
    pop_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        pop_valid |-> $past(pop_en && !empty));

    // R12
    peek_range_chk: assert property (@(posedge clk) disable iff (rst)
        (CW'(peek_off) >= count) |-> (peek_bad && peek_data == '0));

endmodule

bind peek_fifo peek_fifo_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW), .CW(CW)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .push_en   (push_en),
    .pop_en    (pop_en),
    .pop_valid (pop_valid),
    .peek_off  (peek_off),
    .peek_data (peek_data),
    .peek_bad  (peek_bad),
    .count     (count),
    .empty     (empty),
    .full      (full),
    .overflow  (overflow),
    .underflow (underflow)
);

// File: tb/peek_fifo_tb_top.sv
module peek_fifo_tb_top;

    localparam int W  = 8;
    localparam int D  = 8;
    localparam int AW = $clog2(D);
    localparam int CW = AW + 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          push_en = 1'b0;
    logic [W-1:0]  push_data = '0;
    logic          pop_en = 1'b0;
    logic [W-1:0]  pop_data;
    logic          pop_valid;
    logic [AW-1:0] peek_off = '0;
    logic [W-1:0]  peek_data;
    logic          peek_bad;
    logic [CW-1:0] level = '0;
    logic [CW-1:0] count;
    logic          empty, half_full, full, at_level, overflow, underflow;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    peek_fifo #(.WIDTH(W), .DEPTH(D)) dut_i (
        .clk(clk), .rst(rst), .push_en(push_en), .push_data(push_data),
        .pop_en(pop_en), .pop_data(pop_data), .pop_valid(pop_valid),
        .peek_off(peek_off), .peek_data(peek_data), .peek_bad(peek_bad),
        .level(level), .count(count), .empty(empty), .half_full(half_full),
        .full(full), .at_level(at_level), .overflow(overflow), .underflow(underflow)
    );

    // Vector: push | pop | data[8] | cnt[4] | pv | pd[8] | ovf | unf  (25 bits)
    localparam int NV = 26;
    localparam logic [24:0] VEC [NV] = '{
        {1'b0, 1'b1, 8'h00, 4'd0, 1'b0, 8'h00, 1'b0, 1'b1},
        {1'b1, 1'b0, 8'hA1, 4'd1, 1'b0, 8'h00, 1'b0, 1'b0},
        {1'b1, 1'b0, 8'hA2, 4'd2, 1'b0, 8'h00, 1'b0, 1'b0},
        {1'b1, 1'b1, 8'hA3, 4'd2, 1'b1, 8'hA1, 1'b0, 1'b0},
        {1'b0, 1'b1, 8'h00, 4'd1, 1'b1, 8'hA2, 1'b0, 1'b0},
        {1'b0, 1'b1, 8'h00, 4'd0, 1'b1, 8'hA3, 1'b0, 1'b0},
        {1'b1, 1'b1, 8'hB0, 4'd1, 1'b0, 8'h00, 1'b0, 1'b1},
        {1'b0, 1'b1, 8'h00, 4'd0, 1'b1, 8'hB0, 1'b0, 1'b0},
        {1'b1, 1'b0, 8'hC1, 4'd1, 1'b0, 8'h00, 1'b0, 1'b0},
        {1'b1, 1'b0, 8'hC2, 4'd2, 1'b0, 8'h00, 1'b0, 1'b0},
        {1'b1, 1'b0, 8'hC3, 4'd3, 1'b0, 8'h00, 1'b0, 1'b0},
        {1'b1, 1'b0, 8'hC4, 4'd4, 1'b0, 8'h00, 1'b0, 1'b0},
        {1'b1, 1'b0, 8'hC5, 4'd5, 1'b0, 8'h00, 1'b0, 1'b0},
        {1'b1, 1'b0, 8'hC6, 4'd6, 1'b0, 8'h00, 1'b0, 1'b0},
        {1'b1, 1'b0, 8'hC7, 4'd7, 1'b0, 8'h00, 1'b0, 1'b0},
        {1'b1, 1'b0, 8'hC8, 4'd8, 1'b0, 8'h00, 1'b0, 1'b0},
        {1'b1, 1'b0, 8'hC9, 4'd8, 1'b0, 8'h00, 1'b1, 1'b0},
        {1'b1, 1'b1, 8'hD0, 4'd8, 1'b1, 8'hC1, 1'b0, 1'b0},
        {1'b0, 1'b1, 8'h00, 4'd7, 1'b1, 8'hC2, 1'b0, 1'b0},
        {1'b0, 1'b1, 8'h00, 4'd6, 1'b1, 8'hC3, 1'b0, 1'b0},
        {1'b0, 1'b1, 8'h00, 4'd5, 1'b1, 8'hC4, 1'b0, 1'b0},
        {1'b0, 1'b1, 8'h00, 4'd4, 1'b1, 8'hC5, 1'b0, 1'b0},
        {1'b0, 1'b1, 8'h00, 4'd3, 1'b1, 8'hC6, 1'b0, 1'b0},
        {1'b0, 1'b1, 8'h00, 4'd2, 1'b1, 8'hC7, 1'b0, 1'b0},
        {1'b0, 1'b1, 8'h00, 4'd1, 1'b1, 8'hC8, 1'b0, 1'b0},
        {1'b0, 1'b1, 8'h00, 4'd0, 1'b1, 8'hD0, 1'b0, 1'b0}
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Drive on the falling edge, let one rising edge pass, sample on the next falling edge
    task automatic step(input logic pu, input logic po, input logic [W-1:0] d);
        push_en   = pu;
        pop_en    = po;
        push_data = d;
        @(posedge clk);
        @(negedge clk);
        push_en = 1'b0;
        pop_en  = 1'b0;
        #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL R2 watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] want;
        // R1 reset state
        level = CW'(3);
        repeat (2) @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1", "count", 32'(count), 0);
        chk("R1", "empty", 32'(empty), 1);
        chk("R1", "full", 32'(full), 0);
        chk("R1", "half_full", 32'(half_full), 0);
        chk("R1", "pop_valid", 32'(pop_valid), 0);
        chk("R1", "overflow", 32'(overflow), 0);
        chk("R1", "underflow", 32'(underflow), 0);
        chk("R6", "at_level below", 32'(at_level), 0);
        chk("R12", "peek_bad empty", 32'(peek_bad), 1);
        chk("R12", "peek_data empty", 32'(peek_data), 0);

        // Vector walk: R2 R3 R4 R7 R8 R9 R10
        for (int i = 0; i < NV; i++) begin
            logic [24:0] v;
            v = VEC[i];
            step(v[24], v[23], v[22:15]);
            chk("R3", $sformatf("count v%0d", i), 32'(count), 32'(v[14:11]));
            chk("R4", $sformatf("empty v%0d", i), 32'(empty), 32'(v[14:11] == 4'd0));
            chk("R4", $sformatf("full v%0d", i), 32'(full), 32'(v[14:11] == 4'd8));
            chk("R2", $sformatf("pop_valid v%0d", i), 32'(pop_valid), 32'(v[10]));
            if (v[10]) chk("R2", $sformatf("pop_data v%0d", i), 32'(pop_data), 32'(v[9:2]));
            chk("R9", $sformatf("overflow v%0d", i), 32'(overflow), 32'(v[1]));
            chk("R10", $sformatf("underflow v%0d", i), 32'(underflow), 32'(v[0]));
        end

        // Level, half-full and peek
        level = CW'(5);
        for (int k = 0; k < 5; k++) step(1'b1, 1'b0, W'(8'hE0 + k));
        chk("R5", "half_full at 5", 32'(half_full), 1);
        chk("R6", "at_level equal", 32'(at_level), 1);
        level = CW'(6);
        #1;
        chk("R6", "at_level below 6", 32'(at_level), 0);
        level = CW'(5);
        peek_off = AW'(0); #1;
        chk("R11", "peek off0", 32'(peek_data), 32'h E0);
        chk("R12", "peek_bad in range", 32'(peek_bad), 0);
        peek_off = AW'(4); #1;
        chk("R11", "peek off4", 32'(peek_data), 32'h E4);
        peek_off = AW'(5); #1;
        chk("R12", "peek_bad at count", 32'(peek_bad), 1);
        chk("R12", "peek_data at count", 32'(peek_data), 0);
        step(1'b0, 1'b0, '0);
        chk("R11", "count after peek", 32'(count), 5);
        peek_off = AW'(0); #1;
        chk("R11", "head unchanged", 32'(peek_data), 32'h E0);
        step(1'b0, 1'b1, '0);
        chk("R2", "pop E0", 32'(pop_data), 32'h E0);
        step(1'b0, 1'b1, '0);
        chk("R2", "pop E1", 32'(pop_data), 32'h E1);
        chk("R5", "half_full at 3", 32'(half_full), 0);
        chk("R11", "peek follows head", 32'(peek_data), 32'h E2);

        // Fill across the wrap point
        for (int k = 0; k < 5; k++) step(1'b1, 1'b0, W'(8'hF0 + k));
        chk("R4", "full after wrap fill", 32'(full), 1);
        chk("R3", "count at DEPTH", 32'(count), 8);
        for (int k = 0; k < D; k++) begin
            peek_off = AW'(k); #1;
            want = (k < 3) ? W'(8'hE2 + k) : W'(8'hF0 + k - 3);
            chk("R11", $sformatf("peek sweep %0d", k), 32'(peek_data), 32'(want));
        end
        level = '0; #1;
        chk("R6", "at_level zero", 32'(at_level), 1);

        // Dropped push keeps contents
        step(1'b1, 1'b0, 8'h55);
        chk("R9", "overflow pulse", 32'(overflow), 1);
        peek_off = AW'(7); #1;
        chk("R9", "tail unchanged", 32'(peek_data), 32'h F4);
        step(1'b0, 1'b0, '0);
        chk("R9", "overflow one cycle", 32'(overflow), 0);

        // Reset while full
        rst = 1'b1;
        step(1'b0, 1'b0, '0);
        rst = 1'b0;
        chk("R1", "count after reset", 32'(count), 0);
        chk("R1", "empty after reset", 32'(empty), 1);
        chk("R1", "full after reset", 32'(full), 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule